// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical memory address, the way a real-mode segmented processor does. It keeps four segment registers (extra, code, stack, data) and an instruction pointer. Each access names its kind: an instruction fetch, a stack push or pop, or a data access. The block picks the segment from that kind and, for data accesses only, from an optional override. It then adds the segment, shifted left four places, to the offset.

The instruction pointer gives the offset of the next code byte. It moves forward one step for each opcode or operand byte that the fetch logic reports as taken. A synchronous write port loads any segment register, or loads the pointer to perform a jump. The physical address and the chosen segment are combinational from the current register values and the access inputs, so the bus logic can use them in the same cycle.

Top module: `seg_agu`

## Requirements
- R1: `phys_addr` equals the selected segment value times 16 plus the offset, so segment 1234h with offset 5678h gives 179B8h.
- R2: The sum is taken modulo 2^20 and any carry out of bit 19 is dropped, so segment FFFFh with offset FFFFh gives 0FFEFh.
- R3: When `acc_kind` = 00 (fetch), the code segment is used with the instruction pointer as offset, and `seg_used` = 01 whatever `ovr_en` and `ovr_sel` hold.
- R4: When `acc_kind` = 01 (stack), the stack segment is used with `data_off` as offset, and `seg_used` = 10 whatever `ovr_en` and `ovr_sel` hold.
- R5: When `acc_kind[1]` = 1 (data) and `ovr_en` = 0, the data segment is used with `data_off`, and `seg_used` = 11.
- R6: When `acc_kind[1]` = 1 and `ovr_en` = 1, the segment named by `ovr_sel` is used (00 extra, 01 code, 10 stack, 11 data), and `seg_used` equals `ovr_sel`.
- R7: A cycle with `fetch_step` = 1 and no pointer load raises `ip_out` by one at the next clock edge. Without a step or a load, `ip_out` holds its value.
- R8: A step from FFFFh gives 0000h, and the code segment keeps its value.
- R9: With `wr_en` = 1, `wr_value` is written at the clock edge into the target named by `wr_sel`: 000 extra, 001 code, 010 stack, 011 data, 100 instruction pointer. The codes 101 to 111 change no register.
- R10: A pointer load and a `fetch_step` in the same cycle leave `ip_out` equal to the loaded value.
- R11: A synchronous reset (`rst` = 1) clears all four segment registers and the pointer to zero.
- R12: `phys_addr` and `seg_used` follow changes on `acc_kind`, `ovr_en`, `ovr_sel` and `data_off` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 stack, 1x data |
| ovr_en | input | 1 | Segment override requested |
| ovr_sel | input | 2 | Override segment code |
| data_off | input | 16 | Offset for stack and data accesses |
| fetch_step | input | 1 | One code byte was fetched this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target code |
| wr_value | input | 16 | Value to write |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Code of the segment chosen |
| ip_out | output | 16 | Current instruction pointer |

## Verification
A jump load and a byte-fetch step can arrive in the same cycle, and both act on the pointer. The bench raises `fetch_step` while it writes the pointer through code 100, then expects the loaded value and not that value plus one. It also writes a segment register while a step is under way, then expects the pointer to advance and the new segment to be in place. Both results are read through `ip_out` and through fetch and override addresses.

// File: rtl/seg_agu_pkg.sv
`timescale 1ns/1ps
package seg_agu_pkg;

  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_STACK = 2'b01,
    ACC_DATA  = 2'b10,
    ACC_DATA2 = 2'b11
  } acc_kind_e;

  localparam int unsigned NUM_SEG = 4;
  localparam logic [2:0]  WR_IP   = 3'b100;

endpackage

// File: rtl/seg_bank.sv
`timescale 1ns/1ps
module seg_bank #(
  parameter int unsigned SEG_W = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     wr_en,
  input  logic [2:0]                               wr_sel,
  input  logic [SEG_W-1:0]                         wr_value,
  output logic [seg_agu_pkg::NUM_SEG-1:0][SEG_W-1:0] seg_q
);
  import seg_agu_pkg::*;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic hit;
    assign hit = wr_en && (wr_sel == 3'(g));
    always_ff @(posedge clk) begin
      if (rst)      seg_q[g] <= '0;
      else if (hit) seg_q[g] <= wr_value;
    end
  end

endmodule

// File: rtl/ip_ctr.sv
`timescale 1ns/1ps
module ip_ctr #(
  parameter int unsigned OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [OFF_W-1:0] load_val,
  output logic [OFF_W-1:0] ip_q
);

  // A jump load wins over a byte step in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)       ip_q <= '0;
    else if (load) ip_q <= load_val;
    else if (step) ip_q <= ip_q + 1'b1;
  end

endmodule

// File: rtl/seg_pick.sv
`timescale 1ns/1ps
module seg_pick #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16
) (
  input  logic [1:0]                               acc_kind,
  input  logic                                     ovr_en,
  input  logic [1:0]                               ovr_sel,
  input  logic [seg_agu_pkg::NUM_SEG-1:0][SEG_W-1:0] seg_q,
  input  logic [OFF_W-1:0]                         ip,
  input  logic [OFF_W-1:0]                         data_off,
  output logic [1:0]                               seg_id,
  output logic [SEG_W-1:0]                         seg_val,
  output logic [OFF_W-1:0]                         offset
);
  import seg_agu_pkg::*;

  seg_id_e pick;

  always_comb begin
    unique case (acc_kind_e'(acc_kind))
      ACC_FETCH: begin
        pick   = SEG_CS;
        offset = ip;
      end
      ACC_STACK: begin
        pick   = SEG_SS;
        offset = data_off;
      end
      default: begin
        pick   = ovr_en ? seg_id_e'(ovr_sel) : SEG_DS;
        offset = data_off;
      end
    endcase
  end

  assign seg_id  = pick;
  assign seg_val = seg_q[pick];

endmodule

// File: rtl/pa_adder.sv
`timescale 1ns/1ps
module pa_adder #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg_val,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  pa
);

  logic [PA_W-1:0] seg_sh;
  logic [PA_W-1:0] off_ext;

  assign seg_sh  = {seg_val, {SHIFT{1'b0}}};
  assign off_ext = PA_W'(offset);
  // Carry out of the top bit is dropped by the sized sum.
  assign pa      = seg_sh + off_ext;

endmodule

// File: rtl/seg_agu.sv
`timescale 1ns/1ps
module seg_agu #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       acc_kind,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  input  logic [OFF_W-1:0] data_off,
  input  logic             fetch_step,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [OFF_W-1:0] wr_value,
  output logic [PA_W-1:0]  phys_addr,
  output logic [1:0]       seg_used,
  output logic [OFF_W-1:0] ip_out
);
  import seg_agu_pkg::*;

  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [SEG_W-1:0]              seg_val;
  logic [OFF_W-1:0]              offset;
  logic                          ip_load;

  assign ip_load = wr_en && (wr_sel == WR_IP);

  seg_bank #(.SEG_W(SEG_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_value (SEG_W'(wr_value)),
    .seg_q    (seg_q)
  );

  ip_ctr #(.OFF_W(OFF_W)) u_ip (
    .clk      (clk),
    .rst      (rst),
    .step     (fetch_step),
    .load     (ip_load),
    .load_val (wr_value),
    .ip_q     (ip_out)
  );

  seg_pick #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_pick (
    .acc_kind (acc_kind),
    .ovr_en   (ovr_en),
    .ovr_sel  (ovr_sel),
    .seg_q    (seg_q),
    .ip       (ip_out),
    .data_off (data_off),
    .seg_id   (seg_used),
    .seg_val  (seg_val),
    .offset   (offset)
  );

  pa_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
    .seg_val (seg_val),
    .offset  (offset),
    .pa      (phys_addr)
  );

endmodule

// File: rtl/seg_agu_chk.sv
`timescale 1ns/1ps
module seg_agu_chk #(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned PA_W  = 20
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       acc_kind,
  input logic             ovr_en,
  input logic [1:0]       ovr_sel,
  input logic             fetch_step,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic [OFF_W-1:0] wr_value,
  input logic [PA_W-1:0]  phys_addr,
  input logic [1:0]       seg_used,
  input logic [OFF_W-1:0] ip_out
);

  logic jump;
  assign jump = wr_en && (wr_sel == 3'b100);

  p_fetch_cs_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'b00) |-> (seg_used == 2'b01));

  p_fetch_off_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'b00) |-> (phys_addr[3:0] == ip_out[3:0]));

  p_stack_ss_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'b01) |-> (seg_used == 2'b10));

  p_data_dflt_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_kind[1] && !ovr_en) |-> (seg_used == 2'b11));

  p_data_ovr_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_kind[1] && ovr_en) |-> (seg_used == ovr_sel));

  p_ip_step_r7: assert property (@(posedge clk) disable iff (rst)
    (fetch_step && !jump) |=> (ip_out == OFF_W'($past(ip_out) + 1'b1)));

  p_ip_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!fetch_step && !jump) |=> $stable(ip_out));

  p_ip_load_r10: assert property (@(posedge clk) disable iff (rst)
    jump |=> (ip_out == $past(wr_value)));

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (ip_out == '0));

endmodule

bind seg_agu seg_agu_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_kind   (acc_kind),
  .ovr_en     (ovr_en),
  .ovr_sel    (ovr_sel),
  .fetch_step (fetch_step),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_value   (wr_value),
  .phys_addr  (phys_addr),
  .seg_used   (seg_used),
  .ip_out     (ip_out)
);

// File: tb/seg_agu_bench.sv
`timescale 1ns/1ps
module seg_agu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_kind = 2'b00;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = 2'b00;
  logic [15:0] data_off = '0;
  logic        fetch_step = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_value = '0;
  logic [19:0] phys_addr;
  logic [1:0]  seg_used;
  logic [15:0] ip_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  seg_agu u_seg_agu (
    .clk(clk), .rst(rst), .acc_kind(acc_kind), .ovr_en(ovr_en),
    .ovr_sel(ovr_sel), .data_off(data_off), .fetch_step(fetch_step),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_value(wr_value),
    .phys_addr(phys_addr), .seg_used(seg_used), .ip_out(ip_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] sel, logic [15:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_value = val;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic acc(logic [1:0] k, logic oe, logic [1:0] os, logic [15:0] off);
    acc_kind = k; ovr_en = oe; ovr_sel = os; data_off = off;
    #1;
  endtask

  task automatic t_reset();
    acc(2'b00, 1'b0, 2'b00, 16'h0);
    chk("R11 ip after reset", 32'(ip_out), 32'h0);
    chk("R11 fetch addr after reset", 32'(phys_addr), 32'h0);
    tick();
    wr(3'b011, 16'hABCD);
    wr(3'b100, 16'h1234);
    rst = 1'b1; tick(); rst = 1'b0;
    acc(2'b10, 1'b0, 2'b00, 16'h0);
    chk("R11 data seg cleared", 32'(phys_addr), 32'h0);
    chk("R11 ip cleared", 32'(ip_out), 32'h0);
    tick();
  endtask

  task automatic t_sum();
    wr(3'b011, 16'h1234);
    acc(2'b10, 1'b0, 2'b00, 16'h5678);
    chk("R1 1234:5678", 32'(phys_addr), 32'h179B8);
    tick();
  endtask

  task automatic t_wrap();
    wr(3'b000, 16'hFFFF);
    acc(2'b10, 1'b1, 2'b00, 16'hFFFF);
    chk("R2 carry dropped", 32'(phys_addr), 32'h0FFEF);
    tick();
  endtask

  task automatic t_kinds();
    wr(3'b000, 16'h1000);
    wr(3'b001, 16'h2000);
    wr(3'b010, 16'h3000);
    wr(3'b011, 16'h4000);
    wr(3'b100, 16'h0010);
    acc(2'b00, 1'b1, 2'b00, 16'h0777);
    chk("R3 fetch addr", 32'(phys_addr), 32'h20010);
    chk("R3 fetch seg", 32'(seg_used), 32'h1);
    acc(2'b01, 1'b1, 2'b11, 16'h0100);
    chk("R4 stack addr", 32'(phys_addr), 32'h30100);
    chk("R4 stack seg", 32'(seg_used), 32'h2);
    acc(2'b10, 1'b0, 2'b00, 16'h0002);
    chk("R5 data default", 32'(phys_addr), 32'h40002);
    chk("R5 data seg", 32'(seg_used), 32'h3);
    tick();
    for (int i = 0; i < 4; i++) begin
      acc(2'b11, 1'b1, 2'(i), 16'h0002);
      chk("R6 override addr", 32'(phys_addr), 32'h10002 + 32'(i) * 32'h10000);
      chk("R6 override seg", 32'(seg_used), 32'(i));
      tick();
    end
  endtask

  task automatic t_step();
    wr(3'b100, 16'h0010);
    fetch_step = 1'b1;
    repeat (3) tick();
    fetch_step = 1'b0;
    acc(2'b00, 1'b0, 2'b00, 16'h0);
    chk("R7 ip after three steps", 32'(ip_out), 32'h0013);
    chk("R7 fetch addr follows ip", 32'(phys_addr), 32'h20013);
    tick();
    #1;
    chk("R7 ip holds when idle", 32'(ip_out), 32'h0013);
    tick();
  endtask

  task automatic t_ipwrap();
    wr(3'b100, 16'hFFFF);
    fetch_step = 1'b1; tick(); fetch_step = 1'b0;
    acc(2'b00, 1'b0, 2'b00, 16'h0);
    chk("R8 ip wraps", 32'(ip_out), 32'h0000);
    chk("R8 code seg kept", 32'(phys_addr), 32'h20000);
    tick();
  endtask

  task automatic t_same_cycle();
    wr(3'b100, 16'h0100);
    fetch_step = 1'b1;
    wr(3'b100, 16'h0400);
    fetch_step = 1'b0;
    #1;
    chk("R10 load beats step", 32'(ip_out), 32'h0400);
    tick();
    fetch_step = 1'b1;
    wr(3'b011, 16'h5000);
    fetch_step = 1'b0;
    acc(2'b10, 1'b0, 2'b00, 16'h0003);
    chk("R9 seg write during step", 32'(phys_addr), 32'h50003);
    chk("R7 step during seg write", 32'(ip_out), 32'h0401);
    tick();
  endtask

  task automatic t_bad_target();
    for (int c = 5; c < 8; c++) wr(3'(c), 16'h9999);
    for (int i = 0; i < 4; i++) begin
      acc(2'b10, 1'b1, 2'(i), 16'h0);
      chk("R9 unused code leaves segment",
          32'(phys_addr), (i == 3) ? 32'h50000 : 32'h10000 * 32'(i + 1));
      tick();
    end
    #1;
    chk("R9 unused code leaves ip", 32'(ip_out), 32'h0401);
    tick();
  endtask

  task automatic t_comb();
    acc(2'b10, 1'b1, 2'b01, 16'h0010);
    chk("R12 first offset", 32'(phys_addr), 32'h20010);
    acc_kind = 2'b01; ovr_en = 1'b0; data_off = 16'h0020;
    #0.5;
    chk("R12 same-cycle change addr", 32'(phys_addr), 32'h30020);
    chk("R12 same-cycle change seg", 32'(seg_used), 32'h2);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_sum();
    t_wrap();
    t_kinds();
    t_step();
    t_ipwrap();
    t_same_cycle();
    t_bad_target();
    t_comb();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule